// File: doc/BRIEF.md
# Remappable Peripheral Pin Crossbar

This block sits between a set of remappable device pins and the on-chip peripherals. In the inward direction, every peripheral input has a 6-bit selector that names the pin feeding it. In the outward direction, every remappable pin has a 6-bit function code that either leaves the pin under ordinary port control or connects one peripheral output to it. Peripheral signals appear as plain vectors: `pin_in` carries the sampled pin levels, `fn_out` carries the peripheral outputs and `port_out` carries the port latch values.

Software programs the selectors and codes through a simple synchronous register bus. A lock bit guards the whole mapping. While the lock is set, the mapping cannot be changed. The lock bit can only be flipped by writing the control register in the cycle right after a two-step key sequence. Pin direction is not handled here. It stays with the port logic, and mapping an output function to a pin leaves that pin's direction alone.

Top module: `pin_crossbar`

## Requirements
- R1: Peripheral input k equals `pin_in[s]`, where s is the selector of input k and s < NPIN.
- R2: The selector register at address 0x10+j holds input 2j in bits 5:0 and input 2j+1 in bits 13:8. The code register at address 0x20+j holds the codes of pins 2j and 2j+1 at the same bit positions.
- R3: Bits 7:6 and 15:14 of every selector and code register read as 0. The key register (0x01), the unused bits of the control register and all unmapped addresses read as 0.
- R4: After reset every pin code is 0, so every `pin_out` follows `port_out`. Every input selector resets to 63 and the lock bit resets to 0.
- R5: While the lock bit is 1, writes to selector and code registers leave them unchanged.
- R6: The lock bit is bit 0 of the control register at 0x00 and reads back there. A write to 0x00 changes the lock only in the cycle right after a write of 16'h0057 to 0x01. That 0x0057 write must itself follow a write of 16'h0046 to 0x01 with no other write in between; idle cycles do not break the sequence. Any other write restarts it, and a control write at any other time has no effect.
- R7: A pin whose code c lies in 1..NFN outputs `fn_out[c-1]`. Bit 0 is comparator 1 output, bit 1 is comparator 2 output, bit 2 is UART1 transmit and bit 3 is UART1 RTS.
- R8: A selector value of NPIN or above feeds a constant 1 to its peripheral input.
- R9: A pin whose code is 0 or greater than NFN outputs `port_out` for that pin.
- R10: `bus_rdata` is combinational on `bus_addr` and the current register contents. A write becomes visible in both the read data and the routing from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_in | input | NPIN | Levels sampled on the remappable pins |
| periph_in | output | NIN | Routed peripheral inputs |
| fn_out | input | NFN | Peripheral outputs, indexed by code minus 1 |
| port_out | input | NPIN | Port latch value for each pin |
| pin_out | output | NPIN | Value driven toward each pin |

## Verification
A register write and the routing it changes can meet in one cycle. The bench writes a selector or code register while the read address points at that same register and while the pin and peripheral vectors toggle. It then expects the old contents and the old routing in the write cycle and the new ones in the following cycle. The lock write and the key sequencer also collide with mapping writes: a mapping write placed between the two key writes, or directly after the lock is set, must be judged against a reference model that updates lock, key state and mapping in the same cycle order as the requirements state.

// File: rtl/pin_crossbar.sv
module pin_crossbar #(
  parameter int NPIN = 16,
  parameter int NIN  = 8,
  parameter int NFN  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [5:0]      bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NIN-1:0]  periph_in,
  input  logic [NFN-1:0]  fn_out,
  input  logic [NPIN-1:0] port_out,
  output logic [NPIN-1:0] pin_out
);
  localparam int NSR = (NIN + 1) / 2;
  localparam int NOR = (NPIN + 1) / 2;
  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_KEY  = 6'h01;
  localparam logic [5:0] A_SEL  = 6'h10;
  localparam logic [5:0] A_OUT  = 6'h20;
  localparam logic [15:0] KEY_A = 16'h0046;
  localparam logic [15:0] KEY_B = 16'h0057;

  logic [NIN*6-1:0]  sel_q;
  logic [NPIN*6-1:0] code_q;
  logic lock_q, key_st_q, armed_q;

  wire key_wr  = bus_we && (bus_addr == A_KEY);
  wire ctrl_wr = bus_we && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '1;
      code_q   <= '0;
      lock_q   <= 1'b0;
      key_st_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      armed_q <= 1'b0;
      if (bus_we) begin
        key_st_q <= key_wr && (bus_wdata == KEY_A);
        armed_q  <= key_wr && (bus_wdata == KEY_B) && key_st_q;
        if (ctrl_wr && armed_q) lock_q <= bus_wdata[0];
        if (!lock_q) begin
          for (int j = 0; j < NSR; j++) begin
            if (bus_addr == A_SEL + 6'(j)) begin
              sel_q[2*j*6 +: 6] <= bus_wdata[5:0];
              if (2*j+1 < NIN) sel_q[(2*j+1)*6 +: 6] <= bus_wdata[13:8];
            end
          end
          for (int j = 0; j < NOR; j++) begin
            if (bus_addr == A_OUT + 6'(j)) begin
              code_q[2*j*6 +: 6] <= bus_wdata[5:0];
              if (2*j+1 < NPIN) code_q[(2*j+1)*6 +: 6] <= bus_wdata[13:8];
            end
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata[0] = lock_q;
    for (int j = 0; j < NSR; j++) begin
      if (bus_addr == A_SEL + 6'(j)) begin
        bus_rdata[5:0] = sel_q[2*j*6 +: 6];
        if (2*j+1 < NIN) bus_rdata[13:8] = sel_q[(2*j+1)*6 +: 6];
      end
    end
    for (int j = 0; j < NOR; j++) begin
      if (bus_addr == A_OUT + 6'(j)) begin
        bus_rdata[5:0] = code_q[2*j*6 +: 6];
        if (2*j+1 < NPIN) bus_rdata[13:8] = code_q[(2*j+1)*6 +: 6];
      end
    end
  end

  genvar gk, gp;
  generate
    for (gk = 0; gk < NIN; gk++) begin : g_in
      wire [5:0] s = sel_q[gk*6 +: 6];
      always_comb begin
        periph_in[gk] = 1'b1;
        for (int p = 0; p < NPIN; p++)
          if (s == 6'(p)) periph_in[gk] = pin_in[p];
      end
      p_absent_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(s) >= NPIN) |-> periph_in[gk]);
    end
    for (gp = 0; gp < NPIN; gp++) begin : g_out
      wire [5:0] c = code_q[gp*6 +: 6];
      always_comb begin
        pin_out[gp] = port_out[gp];
        for (int f = 0; f < NFN; f++)
          if (c == 6'(f + 1)) pin_out[gp] = fn_out[f];
      end
      p_port_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((c == 6'd0) || (32'(c) > NFN)) |-> (pin_out[gp] == port_out[gp]));
    end
  endgenerate

  p_lock_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $past(armed_q && bus_we && bus_addr == A_CTRL));
  p_frozen_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable({sel_q, code_q}));
  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[7:6] == 2'b00) && (bus_rdata[15:14] == 2'b00));
  p_arm_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> $past(key_wr && bus_wdata == KEY_B));
endmodule

// File: tb/sim_pin_crossbar.sv
module sim_pin_crossbar;
  localparam int NPIN = 16, NIN = 8, NFN = 8;

  logic clk = 0, rst_n = 0, we = 0;
  logic [5:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [NPIN-1:0] pin_in = 0, port_out = 0, pin_out;
  logic [NIN-1:0] periph_in;
  logic [NFN-1:0] fn_out = 0;

  always #5 clk = ~clk;

  pin_crossbar #(.NPIN(NPIN), .NIN(NIN), .NFN(NFN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_in), .periph_in(periph_in), .fn_out(fn_out),
    .port_out(port_out), .pin_out(pin_out));

  int tests = 0, fails = 0;
  int msel[NIN];
  int mcode[NPIN];
  int mlock, mst, marm;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [5:0] a);
    logic [15:0] r = 0;
    if (a == 6'h00) r[0] = mlock[0];
    if (a >= 6'h10 && a < 6'h10 + NIN/2) begin
      r[5:0] = 6'(msel[2*(a-6'h10)]); r[13:8] = 6'(msel[2*(a-6'h10)+1]);
    end
    if (a >= 6'h20 && a < 6'h20 + NPIN/2) begin
      r[5:0] = 6'(mcode[2*(a-6'h20)]); r[13:8] = 6'(mcode[2*(a-6'h20)+1]);
    end
    return r;
  endfunction

  function automatic logic [NIN-1:0] exp_pi();
    logic [NIN-1:0] v;
    for (int k = 0; k < NIN; k++) v[k] = (msel[k] < NPIN) ? pin_in[msel[k]] : 1'b1;
    return v;
  endfunction

  function automatic logic [NPIN-1:0] exp_po();
    logic [NPIN-1:0] v;
    for (int p = 0; p < NPIN; p++)
      v[p] = (mcode[p] >= 1 && mcode[p] <= NFN) ? fn_out[mcode[p]-1] : port_out[p];
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NIN; k++) msel[k] = 63;
    for (int p = 0; p < NPIN; p++) mcode[p] = 0;
    mlock = 0; mst = 0; marm = 0;
  endtask

  task automatic cyc(input logic w, input logic [5:0] a, input logic [15:0] d);
    int old_lock, old_st, old_arm;
    we = w; addr = a; wdata = d;
    pin_in = 16'($urandom); port_out = 16'($urandom); fn_out = 8'($urandom);
    #1;
    if (rst_n) begin
      chk("R2 R3 R10 read data", 32'(rdata), 32'(exp_rd(a)));
      chk("R1 R8 periph_in", 32'(periph_in), 32'(exp_pi()));
      chk("R4 R7 R9 pin_out", 32'(pin_out), 32'(exp_po()));
    end
    @(posedge clk);
    old_lock = mlock; old_st = mst; old_arm = marm;
    marm = 0;
    if (!rst_n) model_reset();
    else if (w) begin
      mst  = (a == 6'h01 && d == 16'h0046) ? 1 : 0;
      marm = (a == 6'h01 && d == 16'h0057 && old_st == 1) ? 1 : 0;
      if (a == 6'h00 && old_arm == 1) mlock = int'(d[0]);
      if (old_lock == 0) begin
        if (a >= 6'h10 && a < 6'h10 + NIN/2) begin
          msel[2*(a-6'h10)] = int'(d[5:0]); msel[2*(a-6'h10)+1] = int'(d[13:8]);
        end
        if (a >= 6'h20 && a < 6'h20 + NPIN/2) begin
          mcode[2*(a-6'h20)] = int'(d[5:0]); mcode[2*(a-6'h20)+1] = int'(d[13:8]);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic rd_expect(input logic [5:0] a, input logic [15:0] e, input string tag);
    we = 0; addr = a; #1;
    chk(tag, 32'(rdata), 32'(e));
    cyc(0, a, 0);
  endtask

  task automatic unlock_seq(input logic v);
    cyc(1, 6'h01, 16'h0046);
    cyc(0, 6'h00, 0);
    cyc(1, 6'h01, 16'h0057);
    cyc(1, 6'h00, {15'd0, v});
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    repeat (3) cyc(0, 6'h00, 0);
    rst_n = 1;
    rd_expect(6'h10, 16'h3F3F, "R4 selector reset value");
    rd_expect(6'h20, 16'h0000, "R4 code reset value");
    rd_expect(6'h00, 16'h0000, "R4 lock reset value");
    for (int i = 0; i < 6; i++) cyc(0, 6'(i * 7), 0);
    // R1 R8: pins 3 and 15, nonexistent 16 and 63
    cyc(1, 6'h10, 16'h0F03);
    cyc(1, 6'h11, 16'h3F10);
    cyc(1, 6'h12, 16'h0500);
    rd_expect(6'h11, 16'h3F10, "R2 selector packing");
    // R10 same-cycle write and read of one register
    we = 1; addr = 6'h13; wdata = 16'h0709; #1;
    chk("R10 old value during write", 32'(rdata), 32'h3F3F);
    cyc(1, 6'h13, 16'h0709);
    rd_expect(6'h13, 16'h0709, "R10 new value after write");
    // R7 R9 codes
    cyc(1, 6'h20, 16'h0201);
    cyc(1, 6'h21, 16'h0403);
    cyc(1, 6'h22, 16'h0908);
    cyc(1, 6'h23, 16'h3F00);
    rd_expect(6'h21, 16'h0403, "R2 code packing");
    rd_expect(6'h24, 16'h0000, "R3 untouched code reg");
    cyc(1, 6'h14, 16'hFFFF);
    rd_expect(6'h14, 16'h0000, "R3 unmapped address");
    cyc(1, 6'h15, 16'hFFFF);
    cyc(1, 6'h24, 16'hFFFF);
    rd_expect(6'h24, 16'h3F3F, "R3 reserved bits read 0");
    rd_expect(6'h01, 16'h0000, "R3 key register reads 0");
    for (int i = 0; i < 20; i++) cyc(0, 6'h10 + 6'(i % 4), 0);
    // R6 plain control write ignored
    cyc(1, 6'h00, 16'h0001);
    rd_expect(6'h00, 16'h0000, "R6 control write without keys");
    // R6 sequence broken by a mapping write
    cyc(1, 6'h01, 16'h0046);
    cyc(1, 6'h20, 16'h0101);
    cyc(1, 6'h01, 16'h0057);
    cyc(1, 6'h00, 16'h0001);
    rd_expect(6'h00, 16'h0000, "R6 broken sequence");
    // R6 gap before control write
    cyc(1, 6'h01, 16'h0046);
    cyc(1, 6'h01, 16'h0057);
    cyc(0, 6'h00, 0);
    cyc(1, 6'h00, 16'h0001);
    rd_expect(6'h00, 16'h0000, "R6 late control write");
    // R6 proper lock
    unlock_seq(1'b1);
    rd_expect(6'h00, 16'h0001, "R6 lock set");
    // R5 writes while locked
    cyc(1, 6'h10, 16'h0102);
    cyc(1, 6'h20, 16'h0404);
    rd_expect(6'h10, 16'h0F03, "R5 selector frozen");
    rd_expect(6'h20, 16'h0101, "R5 code frozen");
    for (int i = 0; i < 10; i++) cyc(0, 6'h20 + 6'(i % 4), 0);
    // R6 unlock and write again
    unlock_seq(1'b0);
    rd_expect(6'h00, 16'h0000, "R6 lock cleared");
    cyc(1, 6'h20, 16'h0304);
    rd_expect(6'h20, 16'h0304, "R5 write after unlock");
    for (int i = 0; i < 20; i++) cyc(0, 6'(i), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule